// File: doc/BRIEF.md
# Up-Counting Timer with Overflow Interrupt

This block is a general-purpose up-counter with a small word-addressed register bus. Software loads a starting value, then sets a run bit. The counter then advances by one on every clock until it steps past all-ones. That step sets a sticky overflow flag. The flag drives a level interrupt when the interrupt-enable bit is set.

When the reload-on-overflow bit is clear, an overflow stops the timer. The counter is left at zero, which gives a one-shot event. When the bit is set, the counter is refilled from a separate reload register and keeps running, which gives a periodic event. Loading zero into both the counter and the reload register gives a free-running time base that software can read at any time.

A delay of N cycles is requested by loading all-ones minus N. The run bit passes through a short arming delay before counting begins, so very short intervals cost a few extra cycles.

Top module: `upcount_timer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and the counter does not advance.
- R2: The bus has four word addresses. Address 0 is control: bit 0 is run, bit 1 is reload-on-overflow, bit 2 is interrupt enable. Address 1 is the reload value. Address 2 is the counter: a write loads it and a read returns the live count. Address 3 is status, with the overflow flag in bit 0. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are high. A read is combinational on `bus_addr`.
- R3: Counting starts SYNC_STAGES (default 2) edges after the edge that sets run. After the k-th edge following that write, the count is v+k-2 for k>2, where v is the value that was loaded.
- R4: An edge that counts while the counter holds all-ones sets the overflow flag. With all-ones minus N loaded, the flag is visible after edge N+3 following the start write, so the shortest interval is 3 cycles.
- R5: With reload-on-overflow clear, an overflow clears the run bit and leaves the counter at zero.
- R6: With reload-on-overflow set, an overflow loads the counter from the reload register and counting continues. Later overflows then come every N+1 cycles.
- R7: Clearing run freezes the counter at its current value.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 there has no effect. If an overflow and a clear fall on the same edge, the flag stays set.
- R9: `irq` equals the overflow flag ANDed with the interrupt enable bit. It is a level signal that stays high until software clears the flag or the enable.
- R10: Writing the reload register does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench measures the exact edge of each overflow for one-shot and periodic intervals, including the 3-cycle minimum. A start path that skipped or doubled the arming delay would move `irq` by whole cycles. It also checks that a one-shot leaves run clear and the count at zero, and that a periodic overflow refills from the reload register. A counter that wrapped to zero in periodic mode, or kept running after a one-shot, would show the wrong count. Writing 0 to status, an overflow that lands on the same edge as a clear, and an overflow with the interrupt disabled are each probed. These catch a flag cleared by any write, a clear that beats the set, and an `irq` that ignores the enable bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_AUTO_BIT = 1;
    localparam int CTRL_IE_BIT   = 2;
    localparam int STAT_OVF_BIT  = 0;

    typedef struct packed {
        logic ie;
        logic autoload;
        logic run;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [2:0] bits);
        ctrl_t c;
        c.run      = bits[CTRL_RUN_BIT];
        c.autoload = bits[CTRL_AUTO_BIT];
        c.ie       = bits[CTRL_IE_BIT];
        return c;
    endfunction

    function automatic logic [2:0] pack_ctrl(input ctrl_t c);
        logic [2:0] bits;
        bits = '0;
        bits[CTRL_RUN_BIT]  = c.run;
        bits[CTRL_AUTO_BIT] = c.autoload;
        bits[CTRL_IE_BIT]   = c.ie;
        return bits;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    bus_wdata,
    input  logic                ovf_evt,
    input  logic [CNT_W-1:0]    count_q,
    input  logic                ovf_flag,
    output ctrl_t               ctrl_q,
    output logic [CNT_W-1:0]    reload_q,
    output logic                load_en,
    output logic [CNT_W-1:0]    load_val,
    output logic                clr_req,
    output logic [CNT_W-1:0]    bus_rdata
);

    logic     wr_any;
    reg_sel_e sel;

    assign wr_any = bus_sel & bus_wr;
    assign sel    = reg_sel_e'(bus_addr);

    // control: software write wins over the one-shot auto-stop
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_any && sel == REG_CTRL) begin
            ctrl_q <= unpack_ctrl(bus_wdata[2:0]);
        end else if (ovf_evt && !ctrl_q.autoload) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (wr_any && sel == REG_RELOAD) begin
            reload_q <= bus_wdata;
        end
    end

    assign load_en  = wr_any && (sel == REG_COUNT);
    assign load_val = bus_wdata;
    assign clr_req  = wr_any && (sel == REG_STATUS) && bus_wdata[STAT_OVF_BIT];

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_CTRL:   bus_rdata[2:0] = pack_ctrl(ctrl_q);
            REG_RELOAD: bus_rdata = reload_q;
            REG_COUNT:  bus_rdata = count_q;
            REG_STATUS: bus_rdata[STAT_OVF_BIT] = ovf_flag;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             autoload,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic go;

    generate
        if (SYNC_STAGES > 0) begin : g_arm
            localparam logic [SYNC_STAGES-1:0] ARM_ONE = 1;
            logic [SYNC_STAGES-1:0] arm_q;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    arm_q <= '0;
                end else begin
                    arm_q <= (arm_q << 1) | ARM_ONE;
                end
            end
            assign go = run & arm_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign go = run;
        end
    endgenerate

    assign ovf_evt = go && (count_q == CNT_MAX) && !load_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= load_val;
        end else if (ovf_evt) begin
            count_q <= autoload ? reload_val : '0;
        end else if (go) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst,
    input  logic ovf_evt,
    input  logic clr_req,
    input  logic ie,
    output logic ovf_flag,
    output logic irq
);

    // a new overflow beats a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
        end else if (ovf_evt) begin
            ovf_flag <= 1'b1;
        end else if (clr_req) begin
            ovf_flag <= 1'b0;
        end
    end

    assign irq = ovf_flag & ie;

endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    bus_wdata,
    output logic [CNT_W-1:0]    bus_rdata,
    output logic                irq
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_val;
    logic             load_en;
    logic             clr_req;
    logic             ovf_evt;
    logic             ovf_flag;
    logic             run_q;
    logic             auto_q;
    logic             ie_q;

    assign run_q  = ctrl_q.run;
    assign auto_q = ctrl_q.autoload;
    assign ie_q   = ctrl_q.ie;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ovf_evt   (ovf_evt),
        .count_q   (count_q),
        .ovf_flag  (ovf_flag),
        .ctrl_q    (ctrl_q),
        .reload_q  (reload_q),
        .load_en   (load_en),
        .load_val  (load_val),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    tmr_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .autoload   (auto_q),
        .load_en    (load_en),
        .load_val   (load_val),
        .reload_val (reload_q),
        .count_q    (count_q),
        .ovf_evt    (ovf_evt)
    );

    tmr_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .ovf_evt  (ovf_evt),
        .clr_req  (clr_req),
        .ie       (ie_q),
        .ovf_flag (ovf_flag),
        .irq      (irq)
    );

endmodule

// File: rtl/upcount_timer_chk.sv
module upcount_timer_chk #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             irq,
    input logic             run_q,
    input logic             auto_q,
    input logic             ovf_flag,
    input logic             ovf_evt,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] reload_q
);

    logic ctrl_wr, count_wr, stat_wr;
    assign ctrl_wr  = bus_sel && bus_wr && bus_addr == 2'd0;
    assign count_wr = bus_sel && bus_wr && bus_addr == 2'd2;
    assign stat_wr  = bus_sel && bus_wr && bus_addr == 2'd3;

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !count_wr) |=> $stable(count_q));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && !auto_q && !ctrl_wr && !count_wr) |=> (!run_q && count_q == '0));

    // R6
    reload_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && auto_q && !count_wr) |=> (count_q == $past(reload_q)));

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_wr && !stat_wr) |=> irq);

    generate
        if (SYNC_STAGES > 0) begin : g_lat
            // R3
            start_delay_chk: assert property (@(posedge clk) disable iff (rst)
                ($rose(run_q) && !count_wr) |=> $stable(count_q));
        end
    endgenerate

endmodule

bind upcount_timer upcount_timer_chk #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .run_q    (run_q),
    .auto_q   (auto_q),
    .ovf_flag (ovf_flag),
    .ovf_evt  (ovf_evt),
    .count_q  (count_q),
    .reload_q (reload_q)
);

// File: tb/upcount_timer_bench.sv
`timescale 1ns/1ps
module upcount_timer_bench;

    localparam int          W   = 32;
    localparam logic [W-1:0] MAX = '1;
    localparam int          LAT = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    upcount_timer u_upcount_timer (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // {reload-on-overflow, N}
    localparam logic [W:0] VECS [0:3] = '{
        {1'b0, 32'd0},
        {1'b0, 32'd20},
        {1'b1, 32'd3},
        {1'b1, 32'd9}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write happens on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (!irq && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int k;

        idle(3);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reg after reset", v, '0);
        end
        chk("R1 irq after reset", {31'b0, irq}, '0);
        idle(5);
        rd(2'd2, v);
        chk("R1 counter idle", v, '0);

        // table: one-shot and periodic intervals
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] n;
            logic         au;
            n  = VECS[i][W-1:0];
            au = VECS[i][W];
            wr(2'd1, MAX - n);
            wr(2'd2, MAX - n);
            wr(2'd0, {29'b0, 1'b1, au, 1'b1});
            wait_irq(k);
            chk("R4 overflow edge", k, n + LAT + 1);
            rd(2'd2, v);
            if (au) begin
                chk("R6 refill from reload", v, MAX - n);
                wr(2'd3, 32'd1);
                chk("R8 clear drops irq", {31'b0, irq}, '0);
                wait_irq(k);
                chk("R6 periodic spacing", k, n);
            end else begin
                chk("R5 one-shot count zero", v, '0);
                rd(2'd0, v);
                chk("R5 one-shot run cleared", v, 32'h4);
            end
            wr(2'd0, '0);
            wr(2'd3, 32'd1);
        end

        // R3 / R7 free-running from zero, then halt
        wr(2'd1, '0);
        wr(2'd2, '0);
        wr(2'd0, 32'h3);
        idle(10);
        rd(2'd2, v);
        chk("R3 start latency count", v, 32'd8);
        wr(2'd0, '0);
        rd(2'd2, v);
        chk("R7 count at halt", v, 32'd9);
        idle(5);
        rd(2'd2, v);
        chk("R7 count frozen", v, 32'd9);

        // R10 reload write leaves counter alone
        wr(2'd1, 32'h1234);
        rd(2'd2, v);
        chk("R10 counter untouched", v, 32'd9);
        rd(2'd1, v);
        chk("R2 reload readback", v, 32'h1234);

        // R9 / R8 interrupt enable and write-one-to-clear
        wr(2'd2, MAX - 32'd3);
        wr(2'd0, 32'h1);
        idle(8);
        rd(2'd3, v);
        chk("R9 flag set with ie off", v, 32'd1);
        chk("R9 irq masked", {31'b0, irq}, '0);
        wr(2'd0, 32'h4);
        chk("R9 irq on enable", {31'b0, irq}, 32'd1);
        idle(3);
        chk("R9 irq held", {31'b0, irq}, 32'd1);
        wr(2'd3, 32'd0);
        rd(2'd3, v);
        chk("R8 write zero ignored", v, 32'd1);
        wr(2'd3, 32'd1);
        rd(2'd3, v);
        chk("R8 write one clears", v, '0);
        chk("R8 irq low after clear", {31'b0, irq}, '0);

        // R8 set beats clear: overflow on every edge
        wr(2'd1, MAX);
        wr(2'd2, MAX);
        wr(2'd0, 32'h7);
        idle(5);
        wr(2'd3, 32'd1);
        rd(2'd3, v);
        chk("R8 set wins over clear", v, 32'd1);
        wr(2'd0, '0);
        wr(2'd3, 32'd1);
        rd(2'd3, v);
        chk("R8 clear after stop", v, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule